// File: doc/BRIEF.md
# Initiator Byte Handshake Responder

This block sits on the initiator side of a parallel peripheral bus and answers each byte request from the target during an information phase. The target drives three phase lines: message, command/data and in/out. It also raises a request strobe. The block resynchronises the request strobe into its own clock domain, decodes the phase and picks the transfer direction from the in/out line. When the target sends, the block captures the byte and its parity bit. When the initiator sends, it takes a byte from a valid/ready host port and drives it onto the bus with generated parity. In both directions it then raises the acknowledge strobe and holds it until the target withdraws its request.

Each completed byte is reported to the host as a one-cycle pulse. The pulse carries the byte, the phase bits, the direction and, for received bytes, a parity-error flag. Arbitration, selection and attention signalling are outside this block. The request line is sampled through a synchroniser, so it may change at any time relative to the local clock. The phase lines and the inbound data must be stable from the time the request is raised.

Top module: `rq_responder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ack_out`, `bus_drive_en`, `tx_ready` and `xfer_valid` are all low.
- R2: For a target-to-initiator byte (`io_in`=1), `ack_out` is first seen high after the 4th rising edge following the rise of `req_in`, and not before. `xfer_valid` is high in that same cycle and only in that cycle.
- R3: A received byte is reported with `xfer_data` equal to `bus_data_in`, `xfer_dir`=1 and `xfer_phase` = {`msg_in`,`cd_in`,`io_in`} (bit 2 message, bit 1 command/data, bit 0 in/out). `bus_drive_en` stays low for the whole read.
- R4: `xfer_perr` is 1 exactly when the nine bits {`bus_par_in`,`bus_data_in`} of a received byte hold an even number of ones. The required parity is odd. `xfer_perr` is 0 for sent bytes.
- R5: Once high, `ack_out` stays high while `req_in` is high. It is still high after the 2nd edge following the fall of `req_in` and is low after the 3rd.
- R6: For an initiator-to-target byte (`io_in`=0) with a host byte waiting, `tx_ready` is high after the 3rd edge following the rise of `req_in`. The byte is accepted on the next edge, and `bus_drive_en` and `xfer_valid` go high after the 4th edge. `ack_out` goes high one cycle later, after the 5th edge.
- R7: While `bus_drive_en` is high, `bus_data_out` equals the accepted byte and `bus_par_out` makes the nine bits odd. Both stay unchanged until `bus_drive_en` drops, which happens on the same edge as `ack_out` falls. A sent byte is reported with `xfer_dir`=0 and the phase bits.
- R8: If no host byte is valid when a write request arrives, `ack_out` and `bus_drive_en` stay low for as long as it takes. Once `tx_valid` rises, the byte is accepted on the next edge, driven after that edge, and acknowledged one edge later.
- R9: Phase codes with `msg_in`=1 and `cd_in`=0 are reserved. A request in such a phase gets no acknowledge, no drive and no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 1 | Target byte request, asynchronous, active high |
| cd_in | input | 1 | Phase line: command (1) or data (0) |
| io_in | input | 1 | Phase line: target to initiator (1) or initiator to target (0) |
| msg_in | input | 1 | Phase line: message phase |
| bus_data_in | input | 8 | Data byte from the bus |
| bus_par_in | input | 1 | Parity bit from the bus |
| bus_data_out | output | 8 | Byte driven onto the bus, zero when not driving |
| bus_par_out | output | 1 | Odd parity bit driven with the byte |
| bus_drive_en | output | 1 | Output enable for the data and parity drivers |
| ack_out | output | 1 | Acknowledge strobe, active high |
| tx_valid | input | 1 | Host has a byte to send |
| tx_data | input | 8 | Host byte to send |
| tx_ready | output | 1 | Host byte is taken on this edge when tx_valid is high |
| xfer_valid | output | 1 | One-cycle report of a completed byte |
| xfer_data | output | 8 | Byte moved |
| xfer_phase | output | 3 | Phase bits {message, command/data, in/out} |
| xfer_dir | output | 1 | 1 for received, 0 for sent |
| xfer_perr | output | 1 | Parity error on a received byte |

## Verification
The bench sweeps every byte value through a read with both correct and wrong parity. It also sends every byte value out. It checks the exact edge on which the acknowledge rises and falls, so a design that skipped a synchroniser stage or the sample cycle would acknowledge one edge early and be caught. A write whose host byte arrives late checks that the design neither acknowledges nor drives while it waits, and that it leaves a setup cycle between driving the byte and raising the acknowledge. The reserved phase codes are also tried, because a decoder that only looked at the in/out line would answer them.

// File: rtl/rq_pkg.sv
// Shared types for the byte handshake responder.
// Assumes the phase bits are ordered {message, command/data, in/out}.
package rq_pkg;

    typedef enum logic [2:0] {
        PH_DATA_OUT = 3'b000,
        PH_DATA_IN  = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_STATUS   = 3'b011,
        PH_RSV_OUT  = 3'b100,
        PH_RSV_IN   = 3'b101,
        PH_MSG_OUT  = 3'b110,
        PH_MSG_IN   = 3'b111
    } phase_e;

    typedef enum logic [2:0] {
        HS_IDLE  = 3'd0,
        HS_RCAPT = 3'd1,
        HS_RACK  = 3'd2,
        HS_WWAIT = 3'd3,
        HS_WSET  = 3'd4,
        HS_WACK  = 3'd5
    } hs_state_e;

    // Reserved phase: message asserted without command/data.
    function automatic logic phase_reserved(input phase_e ph);
        return (ph == PH_RSV_OUT) || (ph == PH_RSV_IN);
    endfunction

    // In/out bit: 1 means target to initiator.
    function automatic logic phase_inbound(input phase_e ph);
        return ph[0];
    endfunction

endpackage

// File: rtl/rq_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 2. Reset value is low.
module rq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rq_parity.sv
// Odd parity for a data word. It gives the parity bit to send and
// flags a received word whose bits, together with its parity bit,
// hold an even number of ones. Purely combinational.
module rq_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] gen_data,
    output logic              gen_par,
    input  logic [DATA_W-1:0] chk_data,
    input  logic              chk_par,
    output logic              chk_err
);
    // Generate: choose the bit that makes the total count odd.
    always_comb gen_par = ~(^gen_data);

    // Check: an even total is an error.
    always_comb chk_err = ~(^{chk_par, chk_data});
endmodule

// File: rtl/rq_engine.sv
// Handshake state machine for one byte per request.
// Reads: one sample cycle after the synchronised request, then
// acknowledge. Writes: wait for a host byte, drive it for one setup
// cycle, then acknowledge. In both directions the acknowledge is held
// until the synchronised request falls. Assumes the phase lines and
// the inbound data are stable while the request is high.
module rq_engine
    import rq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic [2:0]        phase_bits,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              ack,
    output logic              drive_en,
    output logic [DATA_W-1:0] drv_data,
    output logic              xfer_valid,
    output logic [DATA_W-1:0] xfer_data,
    output logic [2:0]        xfer_phase,
    output logic              xfer_dir,
    output logic              xfer_perr
);
    hs_state_e         state_q, state_d;
    phase_e            ph_now;
    phase_e            ph_q;
    logic              accept;
    logic [DATA_W-1:0] drv_q;
    logic              rep_v_q, rep_dir_q, rep_perr_q;
    logic [DATA_W-1:0] rep_data_q;

    assign ph_now = phase_e'(phase_bits);

    // Host handshake: a byte is taken only while a write waits on a live request.
    always_comb begin
        tx_ready = (state_q == HS_WWAIT) && req_s;
        accept   = tx_ready && tx_valid;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:  if (req_s && !phase_reserved(ph_now))
                          state_d = phase_inbound(ph_now) ? HS_RCAPT : HS_WWAIT;
            HS_RCAPT: state_d = HS_RACK;
            HS_RACK:  if (!req_s) state_d = HS_IDLE;
            HS_WWAIT: if (!req_s)     state_d = HS_IDLE;
                      else if (accept) state_d = HS_WSET;
            HS_WSET:  state_d = HS_WACK;
            HS_WACK:  if (!req_s) state_d = HS_IDLE;
            default:  state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Latch the phase when a handshake starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ph_q <= PH_DATA_OUT;
        else if (state_q == HS_IDLE && req_s)   ph_q <= ph_now;
    end

    // Hold the outbound byte from acceptance until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)      drv_q <= '0;
        else if (accept) drv_q <= tx_data;
    end

    // Build the one-cycle transfer report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_v_q    <= 1'b0;
            rep_data_q <= '0;
            rep_dir_q  <= 1'b0;
            rep_perr_q <= 1'b0;
        end else if (state_q == HS_RCAPT) begin
            rep_v_q    <= 1'b1;
            rep_data_q <= rx_data;
            rep_dir_q  <= 1'b1;
            rep_perr_q <= rx_perr;
        end else if (accept) begin
            rep_v_q    <= 1'b1;
            rep_data_q <= tx_data;
            rep_dir_q  <= 1'b0;
            rep_perr_q <= 1'b0;
        end else begin
            rep_v_q    <= 1'b0;
        end
    end

    // Strobes decoded from the registered state.
    always_comb begin
        ack      = (state_q == HS_RACK) || (state_q == HS_WACK);
        drive_en = (state_q == HS_WSET) || (state_q == HS_WACK);
    end

    assign drv_data   = drv_q;
    assign xfer_valid = rep_v_q;
    assign xfer_data  = rep_data_q;
    assign xfer_phase = ph_q;
    assign xfer_dir   = rep_dir_q;
    assign xfer_perr  = rep_perr_q;

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> req_s) else $error("ack rose without request"); // R2
    AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid) else $error("report longer than a cycle"); // R2
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_s) |=> ack) else $error("ack dropped under request"); // R5
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RACK) |-> !drive_en) else $error("drive during read"); // R3
    AST_STALL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_WWAIT && !tx_valid) |=> (!ack && !drive_en)) else $error("ack while stalled"); // R8
    AST_DRV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en)) |-> $stable(drv_data)) else $error("driven byte moved"); // R7
    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && phase_reserved(ph_now)) |=> (state_q == HS_IDLE)) else $error("reserved phase answered"); // R9
endmodule

// File: rtl/rq_responder.sv
// Top of the initiator byte handshake responder. It synchronises the
// request, checks inbound parity, generates outbound parity and wraps
// the handshake engine. Assumes the phase lines and inbound data are
// stable from request rise until the acknowledge is seen.
module rq_responder
    import rq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in,
    input  logic              cd_in,
    input  logic              io_in,
    input  logic              msg_in,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              bus_par_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_par_out,
    output logic              bus_drive_en,
    output logic              ack_out,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              xfer_valid,
    output logic [DATA_W-1:0] xfer_data,
    output logic [2:0]        xfer_phase,
    output logic              xfer_dir,
    output logic              xfer_perr
);
    logic              req_s;
    logic              rx_perr;
    logic              gen_par;
    logic              drive_en;
    logic [DATA_W-1:0] drv_data;

    rq_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_in),
        .q_sync  (req_s)
    );

    rq_parity #(.DATA_W(DATA_W)) i_parity (
        .gen_data (drv_data),
        .gen_par  (gen_par),
        .chk_data (bus_data_in),
        .chk_par  (bus_par_in),
        .chk_err  (rx_perr)
    );

    rq_engine #(.DATA_W(DATA_W)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .phase_bits ({msg_in, cd_in, io_in}),
        .rx_data    (bus_data_in),
        .rx_perr    (rx_perr),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .ack        (ack_out),
        .drive_en   (drive_en),
        .drv_data   (drv_data),
        .xfer_valid (xfer_valid),
        .xfer_data  (xfer_data),
        .xfer_phase (xfer_phase),
        .xfer_dir   (xfer_dir),
        .xfer_perr  (xfer_perr)
    );

    // Gate the bus outputs with the drive enable.
    always_comb begin
        bus_drive_en = drive_en;
        bus_data_out = drive_en ? drv_data : '0;
        bus_par_out  = drive_en ? gen_par  : 1'b0;
    end

    AST_OUT_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_en |-> (^{bus_par_out, bus_data_out}) == 1'b1) else $error("even parity driven"); // R7
    AST_DRIVE_ENDS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> !bus_drive_en) else $error("drive outlived ack"); // R7
endmodule

// File: tb/test_rq_responder.sv
module test_rq_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_in = 1'b0, cd_in = 1'b0, io_in = 1'b0, msg_in = 1'b0;
    logic [7:0] bus_data_in = '0;
    logic       bus_par_in = 1'b0;
    logic [7:0] bus_data_out;
    logic       bus_par_out, bus_drive_en, ack_out;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, xfer_valid, xfer_dir, xfer_perr;
    logic [7:0] xfer_data;
    logic [2:0] xfer_phase;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    rq_responder i_rq_responder (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .cd_in(cd_in), .io_in(io_in),
        .msg_in(msg_in), .bus_data_in(bus_data_in), .bus_par_in(bus_par_in),
        .bus_data_out(bus_data_out), .bus_par_out(bus_par_out),
        .bus_drive_en(bus_drive_en), .ack_out(ack_out), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .xfer_valid(xfer_valid),
        .xfer_data(xfer_data), .xfer_phase(xfer_phase), .xfer_dir(xfer_dir),
        .xfer_perr(xfer_perr)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Target request release: ack high after 2 edges, low after 3.
    task automatic release_req(input logic was_write);
        req_in = 1'b0;
        step(2);
        check(ack_out === 1'b1, "R5 ack held 2 edges after req fall", ack_out, 1);
        if (was_write)
            check(bus_drive_en === 1'b1, "R7 drive held while ack", bus_drive_en, 1);
        step(1);
        check(ack_out === 1'b0, "R5 ack low 3 edges after req fall", ack_out, 0);
        if (was_write)
            check(bus_drive_en === 1'b0, "R7 drive released with ack", bus_drive_en, 0);
        step(1);
    endtask

    task automatic do_read(input logic [7:0] d, input logic p, input logic [2:0] ph);
        logic exp_err;
        exp_err = ~(^{p, d});
        {msg_in, cd_in, io_in} = ph;
        bus_data_in = d;
        bus_par_in  = p;
        req_in      = 1'b1;
        step(3);
        check(ack_out === 1'b0, "R2 no ack before 4th edge", ack_out, 0);
        step(1);
        check(ack_out === 1'b1, "R2 ack after 4th edge", ack_out, 1);
        check(xfer_valid === 1'b1, "R2 report with ack", xfer_valid, 1);
        check(xfer_data === d, "R3 read byte", xfer_data, d);
        check(xfer_dir === 1'b1, "R3 read dir", xfer_dir, 1);
        check(xfer_phase === ph, "R3 read phase", xfer_phase, ph);
        check(xfer_perr === exp_err, "R4 parity flag", xfer_perr, exp_err);
        check(bus_drive_en === 1'b0, "R3 no drive on read", bus_drive_en, 0);
        step(1);
        check(xfer_valid === 1'b0, "R2 single report pulse", xfer_valid, 0);
        check(ack_out === 1'b1, "R5 ack held under req", ack_out, 1);
        release_req(1'b0);
    endtask

    task automatic do_write(input logic [7:0] d, input logic [2:0] ph, input int stall);
        logic [7:0] exp_par;
        exp_par = {7'd0, ~(^d)};
        {msg_in, cd_in, io_in} = ph;
        tx_data  = d;
        tx_valid = (stall == 0);
        req_in   = 1'b1;
        step(3);
        if (stall == 0) begin
            check(tx_ready === 1'b1, "R6 ready after 3rd edge", tx_ready, 1);
        end else begin
            step(stall);
            check(ack_out === 1'b0, "R8 no ack while stalled", ack_out, 0);
            check(bus_drive_en === 1'b0, "R8 no drive while stalled", bus_drive_en, 0);
            tx_valid = 1'b1;
        end
        check(ack_out === 1'b0 && bus_drive_en === 1'b0, "R6 idle before accept", ack_out, 0);
        step(1);
        tx_valid = 1'b0;
        check(bus_drive_en === 1'b1, "R6 drive after accept", bus_drive_en, 1);
        check(ack_out === 1'b0, "R6 setup cycle without ack", ack_out, 0);
        check(xfer_valid === 1'b1 && xfer_dir === 1'b0, "R7 write report", {xfer_valid, xfer_dir}, 2);
        check(xfer_data === d, "R7 write report byte", xfer_data, d);
        check(xfer_phase === ph && xfer_perr === 1'b0, "R4 write phase and no perr",
              {xfer_phase, xfer_perr}, {ph, 1'b0});
        check(bus_data_out === d, "R7 driven byte", bus_data_out, d);
        check(bus_par_out === exp_par[0], "R7 odd parity out", bus_par_out, exp_par[0]);
        step(1);
        check(ack_out === 1'b1, "R6 ack after setup", ack_out, 1);
        step(2);
        check(bus_data_out === d, "R7 byte held", bus_data_out, d);
        release_req(1'b1);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        step(3);
        check(ack_out === 1'b0 && bus_drive_en === 1'b0, "R1 reset strobes", ack_out, 0);
        check(tx_ready === 1'b0 && xfer_valid === 1'b0, "R1 reset host side", tx_ready, 0);
        rst_n = 1'b1;
        step(1);
        check(ack_out === 1'b0 && xfer_valid === 1'b0, "R1 first cycle after reset", ack_out, 0);

        for (int b = 0; b < 256; b++) begin
            for (int p = 0; p < 2; p++) begin
                logic [2:0] ph;
                ph = (b % 3 == 0) ? 3'b001 : ((b % 3 == 1) ? 3'b011 : 3'b111);
                do_read(8'(b), 1'(p), ph);
            end
        end

        for (int b = 0; b < 256; b++) begin
            logic [2:0] ph;
            ph = (b % 3 == 0) ? 3'b000 : ((b % 3 == 1) ? 3'b010 : 3'b110);
            do_write(8'(b), ph, 0);
        end

        for (int s = 1; s < 12; s += 5) do_write(8'(8'hA5 ^ s), 3'b000, s);

        for (int r = 0; r < 2; r++) begin
            {msg_in, cd_in, io_in} = {2'b10, 1'(r)};
            tx_valid = 1'b1;
            req_in = 1'b1;
            for (int i = 0; i < 10; i++) begin
                step(1);
                check(ack_out === 1'b0 && bus_drive_en === 1'b0 && xfer_valid === 1'b0,
                      "R9 reserved phase ignored", {ack_out, bus_drive_en, xfer_valid}, 0);
            end
            req_in = 1'b0;
            tx_valid = 1'b0;
            step(3);
        end

        do_read(8'h3C, 1'b1, 3'b001);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule